// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Unit

This block is the interrupt front end of a small 8-bit processor core. It watches five request lines: one non-maskable line at the top of the priority order, three restart lines (one rising-edge triggered, two level sensitive), and one general request that has no fixed vector. Edge events are captured in small latches. A per-line mask and a global enable gate the maskable lines. A fixed priority encoder picks a winner.

A request is accepted only when the core signals that the current instruction has finished, and never while a bus-hold request is active. On acceptance the unit presents a 16-bit branch target for one cycle. For the general request it instead presents a zero target and asks the core to run an acknowledge cycle, so that an external device can supply the call. Accepting any maskable request clears the global enable. Servicing the edge-triggered restart line clears its latch.

Top module: `vecIrqUnit`

## Requirements
- R1: After reset the global enable is cleared, all three mask bits are set (masked), both edge latches are empty, and `vecValid`, `ackReq`, `vecAddr` and `irqPending` are all zero.
- R2: A rising edge on `edge75Req` is held in a latch until that line is serviced. The input staying high afterwards does not trigger again.
- R3: `lvl65Req` and `lvl55Req` are recognized only while they are high at the sampling edge. A pulse that has dropped before the boundary is lost.
- R4: The non-maskable line is taken only after a rising edge and while it is still high at the boundary. A level that stays high after service does not trigger again.
- R5: Fixed priority, highest first: non-maskable, `edge75Req`, `lvl65Req`, `lvl55Req`, `genReq`. Exactly one line is granted per acceptance.
- R6: Branch targets are 0x0024 for the non-maskable line, 0x003C for `edge75Req`, 0x0034 for `lvl65Req` and 0x002C for `lvl55Req`. `genReq` gives 0x0000.
- R7: `ackReq` pulses together with `vecValid` only when `genReq` is accepted, and never for the other four lines.
- R8: Acceptance happens only at a clock edge where `instrDone` is high. `vecValid` is high for exactly the following cycle, and `vecAddr` is zero whenever `vecValid` is low.
- R9: While `holdReq` is high, no line is accepted, including the non-maskable one, and `irqPending` is low.
- R10: `maskData` bit 2 masks `edge75Req`, bit 1 masks `lvl65Req` and bit 0 masks `lvl55Req` (1 = masked). It is written on `maskWe`. The global enable gates all four maskable lines. The non-maskable line ignores both.
- R11: Accepting any maskable line clears the global enable. Accepting the non-maskable line leaves it unchanged.
- R12: `latch75Clr` empties the `edge75Req` latch without servicing it.
- R13: `enableSet` sets the global enable and `enableClr` clears it. When both are high in the same cycle, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nmiReq | input | 1 | Non-maskable request, edge and level qualified |
| edge75Req | input | 1 | Rising-edge restart request |
| lvl65Req | input | 1 | Level restart request, middle priority |
| lvl55Req | input | 1 | Level restart request, low priority |
| genReq | input | 1 | Non-vectored general request |
| holdReq | input | 1 | Bus-hold request, blocks all acceptance |
| instrDone | input | 1 | Instruction-boundary strobe |
| maskWe | input | 1 | Write strobe for the mask register |
| maskData | input | 3 | New mask bits {edge75, lvl65, lvl55}, 1 = masked |
| enableSet | input | 1 | Sets the global enable |
| enableClr | input | 1 | Clears the global enable |
| latch75Clr | input | 1 | Empties the edge75Req latch |
| irqPending | output | 1 | Some line would be accepted at a boundary now |
| vecValid | output | 1 | One-cycle pulse: a request was accepted |
| vecAddr | output | 16 | Branch target while vecValid, else zero |
| ackReq | output | 1 | Acknowledge cycle requested (general request accepted) |

## Verification
The hardest situation to reach is a non-maskable latch that holds an old edge while the line is low, and then has the line return high. It must be taken once and not again while the line stays high. The stimulus pulses the line, lets a boundary pass with nothing taken, raises the line again, and takes two boundaries in a row. A similar sequence leaves `edge75Req` high across a service and a re-enable. The priority walk raises all five lines together and retires them one boundary at a time, re-enabling in between, so every grant of the encoder appears in order.

// File: rtl/vecIrqPkg.sv
package vecIrqPkg;
  localparam int NUM_SRC = 5;
  // priority index: lower index wins
  localparam int SRC_NMI = 0;
  localparam int SRC_E75 = 1;
  localparam int SRC_L65 = 2;
  localparam int SRC_L55 = 3;
  localparam int SRC_GEN = 4;

  typedef struct packed {
    logic               take;
    logic [NUM_SRC-1:0] grant;
  } irqStrobe_t;
endpackage

// File: rtl/vecIrqEdge.sv
module vecIrqEdge (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  input  logic clrIn,
  output logic held
);
  logic prevLine;
  logic rise;

  assign rise = lineIn & ~prevLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLine <= 1'b0;
      held     <= 1'b0;
    end else begin
      prevLine <= lineIn;
      held     <= (held & ~clrIn) | rise;
    end
  end

  // R2
  edge_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineIn && !prevLine) |=> held);
  // R12
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrIn && !(lineIn && !prevLine)) |=> !held);
endmodule

// File: rtl/vecIrqCtrl.sv
module vecIrqCtrl
  import vecIrqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] liveReq,
  input  logic               instrDone,
  input  logic               holdReq,
  output irqStrobe_t         strobe,
  output logic               irqPending
);
  logic [NUM_SRC-1:0] firstOne;
  logic               anyLive;

  always_comb begin
    logic found;
    found    = 1'b0;
    firstOne = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (liveReq[i] && !found) begin
        firstOne[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign anyLive      = |liveReq;
  assign irqPending   = anyLive & ~holdReq;
  assign strobe.take  = instrDone & ~holdReq & anyLive;
  assign strobe.grant = strobe.take ? firstOne : '0;

  // R5
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> $onehot(strobe.grant));
  // R5
  nmi_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && liveReq[SRC_NMI]) |-> strobe.grant[SRC_NMI]);
  // R9
  hold_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdReq |-> (strobe.grant == '0));
endmodule

// File: rtl/vecIrqPath.sv
module vecIrqPath
  import vecIrqPkg::*;
#(
  parameter int             VEC_W   = 16,
  parameter int             MASK_W  = 3,
  parameter logic [VEC_W-1:0] VEC_NMI = 16'h0024,
  parameter logic [VEC_W-1:0] VEC_E75 = 16'h003C,
  parameter logic [VEC_W-1:0] VEC_L65 = 16'h0034,
  parameter logic [VEC_W-1:0] VEC_L55 = 16'h002C
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               nmiReq,
  input  logic               edge75Req,
  input  logic               lvl65Req,
  input  logic               lvl55Req,
  input  logic               genReq,
  input  logic               maskWe,
  input  logic [MASK_W-1:0]  maskData,
  input  logic               enableSet,
  input  logic               enableClr,
  input  logic               latch75Clr,
  input  irqStrobe_t         strobe,
  output logic [NUM_SRC-1:0] liveReq,
  output logic               vecValid,
  output logic [VEC_W-1:0]   vecAddr,
  output logic               ackReq
);
  localparam int NUM_EDGE = 2;
  localparam logic [VEC_W-1:0] VEC_TAB [NUM_SRC] =
    '{VEC_NMI, VEC_E75, VEC_L65, VEC_L55, {VEC_W{1'b0}}};

  logic [MASK_W-1:0]   maskReg;
  logic                gEnable;
  logic [NUM_EDGE-1:0] edgeIn;
  logic [NUM_EDGE-1:0] edgeClr;
  logic [NUM_EDGE-1:0] edgeHeld;
  logic                maskTake;
  logic [VEC_W-1:0]    nextVec;

  assign edgeIn  = {edge75Req, nmiReq};
  assign edgeClr = {latch75Clr | strobe.grant[SRC_E75], strobe.grant[SRC_NMI]};

  for (genvar g = 0; g < NUM_EDGE; g++) begin : gEdge
    vecIrqEdge u_edge (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (edgeIn[g]),
      .clrIn  (edgeClr[g]),
      .held   (edgeHeld[g])
    );
  end

  assign liveReq[SRC_NMI] = edgeHeld[0] & nmiReq;
  assign liveReq[SRC_E75] = edgeHeld[1] & ~maskReg[2] & gEnable;
  assign liveReq[SRC_L65] = lvl65Req & ~maskReg[1] & gEnable;
  assign liveReq[SRC_L55] = lvl55Req & ~maskReg[0] & gEnable;
  assign liveReq[SRC_GEN] = genReq & gEnable;

  assign maskTake = strobe.take & (|strobe.grant[NUM_SRC-1:1]);

  always_comb begin
    nextVec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strobe.grant[i]) nextVec = nextVec | VEC_TAB[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg  <= '1;
      gEnable  <= 1'b0;
      vecValid <= 1'b0;
      vecAddr  <= '0;
      ackReq   <= 1'b0;
    end else begin
      if (maskWe) maskReg <= maskData;
      if (enableClr || maskTake) gEnable <= 1'b0;
      else if (enableSet)        gEnable <= 1'b1;
      vecValid <= strobe.take;
      vecAddr  <= strobe.take ? nextVec : '0;
      ackReq   <= strobe.take & strobe.grant[SRC_GEN];
    end
  end

  // R7
  ack_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |-> (vecValid && vecAddr == '0));
  // R8
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vecValid |-> (vecAddr == '0));
  // R11
  mask_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskTake |=> !gEnable);
  // R13
  enable_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    enableClr |=> !gEnable);
endmodule

// File: rtl/vecIrqUnit.sv
module vecIrqUnit
  import vecIrqPkg::*;
#(
  parameter int VEC_W  = 16,
  parameter int MASK_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiReq,
  input  logic              edge75Req,
  input  logic              lvl65Req,
  input  logic              lvl55Req,
  input  logic              genReq,
  input  logic              holdReq,
  input  logic              instrDone,
  input  logic              maskWe,
  input  logic [MASK_W-1:0] maskData,
  input  logic              enableSet,
  input  logic              enableClr,
  input  logic              latch75Clr,
  output logic              irqPending,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vecAddr,
  output logic              ackReq
);
  irqStrobe_t         strobe;
  logic [NUM_SRC-1:0] liveReq;

  vecIrqCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .liveReq    (liveReq),
    .instrDone  (instrDone),
    .holdReq    (holdReq),
    .strobe     (strobe),
    .irqPending (irqPending)
  );

  vecIrqPath #(.VEC_W(VEC_W), .MASK_W(MASK_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .nmiReq     (nmiReq),
    .edge75Req  (edge75Req),
    .lvl65Req   (lvl65Req),
    .lvl55Req   (lvl55Req),
    .genReq     (genReq),
    .maskWe     (maskWe),
    .maskData   (maskData),
    .enableSet  (enableSet),
    .enableClr  (enableClr),
    .latch75Clr (latch75Clr),
    .strobe     (strobe),
    .liveReq    (liveReq),
    .vecValid   (vecValid),
    .vecAddr    (vecAddr),
    .ackReq     (ackReq)
  );
endmodule

// File: tb/vecIrqUnit_bench.sv
module vecIrqUnit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiReq = 0, edge75Req = 0, lvl65Req = 0, lvl55Req = 0, genReq = 0;
  logic holdReq = 0, instrDone = 0, maskWe = 0, enableSet = 0, enableClr = 0;
  logic latch75Clr = 0;
  logic [2:0] maskData = 3'b000;
  logic irqPending, vecValid, ackReq;
  logic [15:0] vecAddr;

  always #5 clk = ~clk;

  vecIrqUnit u_vecIrqUnit (.*);

  int errors = 0, checks = 0, cycles = 0;
  bit chkOn = 0, done = 0;
  string curReq = "R1";

  // behavioural reference state
  bit mPrevN, mPrev75, mLatN, mLat75, mIe;
  bit [2:0] mMask;
  bit expValid, expAck;
  int expAddr;
  int vecList[5] = '{'h24, 'h3C, 'h34, 'h2C, 0};

  function automatic bit isLive(int i);
    case (i)
      0: return mLatN && nmiReq;
      1: return mLat75 && !mMask[2] && mIe;
      2: return lvl65Req && !mMask[1] && mIe;
      3: return lvl55Req && !mMask[0] && mIe;
      default: return genReq && mIe;
    endcase
  endfunction

  function automatic int winner();
    for (int i = 0; i < 5; i++) if (isLive(i)) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPrevN = 0; mPrev75 = 0; mLatN = 0; mLat75 = 0; mIe = 0; mMask = 3'b111;
      expValid = 0; expAck = 0; expAddr = 0;
    end else begin
      int w;
      bit take, riseN, rise75;
      w = winner();
      take = instrDone && !holdReq && (w >= 0);
      riseN = nmiReq && !mPrevN;
      rise75 = edge75Req && !mPrev75;
      expValid = take;
      expAddr = take ? vecList[w] : 0;
      expAck = take && (w == 4);
      if (enableClr || (take && w > 0)) mIe = 0;
      else if (enableSet) mIe = 1;
      mLatN = (mLatN && !(take && w == 0)) || riseN;
      mLat75 = (mLat75 && !(latch75Clr || (take && w == 1))) || rise75;
      mPrevN = nmiReq; mPrev75 = edge75Req;
      if (maskWe) mMask = maskData;
    end
  end

  task automatic check(bit ok, string what, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", curReq, what, got, exp);
    end
  endtask

  always @(negedge clk) if (chkOn && !done) begin
    bit expPend;
    expPend = (winner() >= 0) && !holdReq;
    check(irqPending == expPend, "irqPending", irqPending, expPend);
    check(vecValid == expValid, "vecValid", vecValid, expValid);
    check(vecAddr == expAddr[15:0], "vecAddr", vecAddr, expAddr);
    check(ackReq == expAck, "ackReq", ackReq, expAck);
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // boundary strobe, then direct check of the accepted result
  task automatic boundary(bit v, int addr, bit ack);
    tick(1); instrDone = 1;
    tick(1); instrDone = 0;
    check(vecValid == v, "direct vecValid", vecValid, v);
    check(vecAddr == addr[15:0], "direct vecAddr", vecAddr, addr);
    check(ackReq == ack, "direct ackReq", ackReq, ack);
  endtask

  task automatic enable();
    tick(1); enableSet = 1;
    tick(1); enableSet = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    // R1: reset state, masked level request is not pending
    lvl65Req = 1;
    tick(3); rstN = 1; chkOn = 1;
    tick(1);
    check(irqPending == 0, "R1 pending after reset", irqPending, 0);
    boundary(0, 0, 0);
    // R10: unmask all, R13: enable
    curReq = "R10";
    tick(1); maskWe = 1; maskData = 3'b000;
    tick(1); maskWe = 0;
    boundary(0, 0, 0);
    curReq = "R13"; enable();
    // R3/R6: level 6.5 taken, R11: enable now cleared
    curReq = "R3"; boundary(1, 'h34, 0);
    curReq = "R11"; boundary(0, 0, 0);
    lvl65Req = 0;
    // R3: pulse dropped before boundary is lost
    curReq = "R3"; enable();
    lvl55Req = 1; tick(1); lvl55Req = 0;
    tick(2); boundary(0, 0, 0);
    // R2: edge latched then serviced later
    curReq = "R2";
    edge75Req = 1; tick(1); edge75Req = 0; tick(3);
    boundary(1, 'h3C, 0);
    edge75Req = 1; enable(); boundary(1, 'h3C, 0);
    enable(); tick(2); boundary(0, 0, 0);
    // R12: latch clear input
    curReq = "R12";
    edge75Req = 0; tick(1); edge75Req = 1; tick(1);
    latch75Clr = 1; tick(1); latch75Clr = 0;
    boundary(0, 0, 0);
    edge75Req = 0;
    // R4: edge without level, then edge and level, then level only
    curReq = "R4";
    nmiReq = 1; tick(1); nmiReq = 0; tick(2);
    boundary(0, 0, 0);
    nmiReq = 1; tick(2);
    boundary(1, 'h24, 0);
    boundary(0, 0, 0);
    nmiReq = 0;
    // R11: enable survived the non-maskable service
    curReq = "R11"; lvl55Req = 1; boundary(1, 'h2C, 0); lvl55Req = 0;
    // R8: pending requests but no boundary strobe
    curReq = "R8"; enable(); genReq = 1; tick(6);
    check(vecValid == 0, "R8 no boundary", vecValid, 0);
    genReq = 0;
    // R5/R6/R7: all lines, retire in priority order
    curReq = "R5";
    nmiReq = 1; edge75Req = 1; lvl65Req = 1; lvl55Req = 1; genReq = 1; tick(1);
    boundary(1, 'h24, 0);
    boundary(1, 'h3C, 0);
    enable(); boundary(1, 'h34, 0);
    lvl65Req = 0; enable(); boundary(1, 'h2C, 0);
    lvl55Req = 0; curReq = "R7"; enable(); boundary(1, 0, 1);
    nmiReq = 0; edge75Req = 0; genReq = 0;
    // R9: hold blocks non-maskable
    curReq = "R9";
    tick(1); holdReq = 1; nmiReq = 1; tick(2);
    check(irqPending == 0, "R9 pending under hold", irqPending, 0);
    boundary(0, 0, 0);
    holdReq = 0; tick(1);
    boundary(1, 'h24, 0);
    nmiReq = 0;
    // R10: mask bit 1 blocks 6.5; enable off blocks general; nmi ignores both
    curReq = "R10";
    enable(); tick(1); maskWe = 1; maskData = 3'b010; tick(1); maskWe = 0;
    lvl65Req = 1; boundary(0, 0, 0); lvl65Req = 0;
    tick(1); enableClr = 1; tick(1); enableClr = 0;
    genReq = 1; boundary(0, 0, 0); genReq = 0;
    tick(1); maskWe = 1; maskData = 3'b111; tick(1); maskWe = 0;
    nmiReq = 1; tick(2); boundary(1, 'h24, 0); nmiReq = 0;
    // R13: set and clear together, clear wins
    curReq = "R13";
    tick(1); maskWe = 1; maskData = 3'b000; tick(1); maskWe = 0;
    enableSet = 1; enableClr = 1; tick(1); enableSet = 0; enableClr = 0;
    lvl55Req = 1; boundary(0, 0, 0); lvl55Req = 0;
    tick(3);
    finishRun();
  end
endmodule